// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Port

This block sits between a pair of audio converters and a parallel data path. It runs off the system clock, divides it down into a bit clock and a channel clock, and moves stereo samples in both directions on two serial lines. Words for the output line come in on two parallel 24-bit ports, one per channel. Words from the input line are delivered on one parallel port with a one-cycle strobe and a channel flag.

A three-bit mode selects where a word sits inside each 32-bit half-frame. The choices are: one-bit-delayed 24-bit framing, 20-bit framing that starts on the first bit after the channel edge, framing that ends on the last bit of the half-frame (16, 18 or 20 bits), and three mixed modes in which the input line is end-aligned while the output line is start-aligned. A two-bit rate select sets the system clock to 256, 384 or 512 times the sample rate. Changes to the mode and the rate take effect only at the start of a left half-frame, so a frame is never torn.

Top module: `audio_serial_port`

## Requirements
- R1: While reset is asserted, bclk and ws are 1, sdo is 0, rx_valid is 0 and rx_data is 0; the first bclk fall after reset starts a left half-frame.
- R2: One bclk period lasts 4, 6 or 8 system clocks for rate_sel 0, 1 or 2 (3 acts as 2), with bclk low for the first half. Each half-frame lasts 32 bclk periods. ws is 0 for the left half-frame and 1 for the right.
- R3: ws and sdo change only on a bclk fall. sdi is sampled on the bclk rise.
- R4: Mode 0 (delayed 24-bit): output slots 1..24 of a half-frame carry word bits 23..0. All other output slots are 0. The input is read from the same slots.
- R5: Mode 1 (start-aligned 20-bit): output slots 0..19 carry word bits 23..4. All other slots are 0. The input is read from the same slots.
- R6: Modes 2, 3 and 4 (end-aligned 16, 18 or 20 bits): the word occupies the last L slots (32-L..31) on both lines, MSB first, using word bits 23 down to 24-L.
- R7: Modes 5, 6 and 7: the output is framed as in R5. The input is framed as in R6 with L of 16, 18 or 20 respectively.
- R8: At the bclk fall that ends a half-frame, rx_valid pulses for one system clock. rx_data then holds the received word left-aligned, with bits below the word length set to zero. rx_right gives the channel (1 for right).
- R9: The tx_left or tx_right word is captured at the bclk fall that opens its half-frame. Later changes to that input do not alter the word being sent.
- R10: A new fmt or rate_sel value is applied at the first left half-frame that starts after the change. Half-frames already under way finish in the old setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (256/384/512 x fs) |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | System-clock ratio: 0=256, 1=384, 2/3=512 |
| fmt | input | 3 | Framing mode, codes per R4 to R7 |
| tx_left | input | 24 | Left word to send, MSB at bit 23 |
| tx_right | input | 24 | Right word to send, MSB at bit 23 |
| sdi | input | 1 | Serial input line |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Channel clock, 0 = left |
| sdo | output | 1 | Serial output line |
| rx_data | output | 24 | Received word, left-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_right | output | 1 | Channel of rx_data |

## Verification
A bclk fall, and the ws and sdo values that go with it, appear in the system clock after the divide counter reaches zero. The sdi rise sample follows 2, 3 or 4 clocks after that fall. rx_valid rises in the same clock as the bclk fall that closes the half-frame. The bench works from observed bclk edges, with a delay of 1 to 2 ns, and reads rx_valid half a clock after each edge. It records the expected send word at the half-frame's opening fall and the expected receive word when it starts driving sdi. Both are compared against the complete serial word, or the strobe, that arrives one half-frame later.

// File: rtl/audio_serial_port.sv
module audio_serial_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  rate_sel,
  input  logic [2:0]  fmt,
  input  logic [23:0] tx_left,
  input  logic [23:0] tx_right,
  input  logic        sdi,
  output logic        bclk,
  output logic        ws,
  output logic        sdo,
  output logic [23:0] rx_data,
  output logic        rx_valid,
  output logic        rx_right
);

  function automatic logic [2:0] half_of(input logic [1:0] r);
    case (r)
      2'd0:    half_of = 3'd2;
      2'd1:    half_of = 3'd3;
      default: half_of = 3'd4;
    endcase
  endfunction

  function automatic logic [5:0] out_start(input logic [2:0] f);
    case (f)
      3'd0:    out_start = 6'd1;
      3'd2:    out_start = 6'd16;
      3'd3:    out_start = 6'd14;
      3'd4:    out_start = 6'd12;
      default: out_start = 6'd0;
    endcase
  endfunction

  function automatic logic [5:0] out_len(input logic [2:0] f);
    case (f)
      3'd0:    out_len = 6'd24;
      3'd2:    out_len = 6'd16;
      3'd3:    out_len = 6'd18;
      default: out_len = 6'd20;
    endcase
  endfunction

  function automatic logic [5:0] in_start(input logic [2:0] f);
    case (f)
      3'd0:       in_start = 6'd1;
      3'd1:       in_start = 6'd0;
      3'd2, 3'd5: in_start = 6'd16;
      3'd3, 3'd6: in_start = 6'd14;
      default:    in_start = 6'd12;
    endcase
  endfunction

  function automatic logic [5:0] in_len(input logic [2:0] f);
    case (f)
      3'd0:       in_len = 6'd24;
      3'd2, 3'd5: in_len = 6'd16;
      3'd3, 3'd6: in_len = 6'd18;
      default:    in_len = 6'd20;
    endcase
  endfunction

  logic [2:0]  ph;
  logic [5:0]  bitc;
  logic [2:0]  fmt_q;
  logic [1:0]  rate_q;
  logic [23:0] txw, rxw;
  logic        primed;

  wire         fall       = (ph == 3'd0);
  wire         rise       = (ph == half_of(rate_q));
  wire  [5:0]  nbit       = bitc + 6'd1;
  wire         frame_new  = (nbit == 6'd0);
  wire  [4:0]  nslot      = nbit[4:0];
  wire         nws        = nbit[5];
  wire         half_new   = (nslot == 5'd0);
  wire  [2:0]  nfmt       = frame_new ? fmt : fmt_q;
  wire  [1:0]  nrate      = frame_new ? rate_sel : rate_q;
  wire  [23:0] nword      = half_new ? (nws ? tx_right : tx_left) : txw;
  wire  [5:0]  opos       = {1'b0, nslot} - out_start(nfmt);
  wire         obit       = (opos < out_len(nfmt)) ? nword[5'd23 - opos[4:0]] : 1'b0;
  wire  [5:0]  ipos       = {1'b0, bitc[4:0]} - in_start(fmt_q);
  wire         take       = (ipos < in_len(fmt_q));
  wire  [2:0]  ph_top     = {half_of(nrate), 1'b0} - 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= '0;
      bitc     <= '1;
      bclk     <= 1'b1;
      ws       <= 1'b1;
      sdo      <= 1'b0;
      fmt_q    <= '0;
      rate_q   <= '0;
      txw      <= '0;
      rxw      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_right <= 1'b0;
      primed   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (fall) begin
        ph     <= ph_top;
        bclk   <= 1'b0;
        bitc   <= nbit;
        ws     <= nws;
        sdo    <= obit;
        txw    <= nword;
        fmt_q  <= nfmt;
        rate_q <= nrate;
        if (half_new) begin
          rxw    <= '0;
          primed <= 1'b1;
          if (primed) begin
            rx_data  <= rxw;
            rx_valid <= 1'b1;
            rx_right <= ws;
          end
        end
      end else begin
        ph <= ph - 3'd1;
        if (rise) begin
          bclk <= 1'b1;
          if (take) rxw[5'd23 - ipos[4:0]] <= sdi;
        end
      end
    end
  end

endmodule

module asp_checker (
  input logic clk,
  input logic rst_n,
  input logic bclk,
  input logic ws,
  input logic sdo,
  input logic rx_valid,
  input logic rx_right
);

  a_r3_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (ws != $past(ws)) |-> $fell(bclk));

  a_r3_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo != $past(sdo)) |-> $fell(bclk));

  a_r2_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |=> bclk);

  a_r2_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bclk) |=> !bclk);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r8_channel_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (ws != rx_right));

  a_r8_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $fell(bclk));

endmodule

bind audio_serial_port asp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .ws(ws),
  .sdo(sdo), .rx_valid(rx_valid), .rx_right(rx_right)
);

// File: tb/audio_serial_port_bench.sv
`timescale 1ns/1ps
module audio_serial_port_bench;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  rate_sel = 0;
  logic [2:0]  fmt = 0;
  logic [23:0] tx_left = 0, tx_right = 0;
  logic        sdi = 0;
  logic        bclk, ws, sdo, rx_valid, rx_right;
  logic [23:0] rx_data;

  always #10 clk = ~clk;

  audio_serial_port u_audio_serial_port (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .fmt(fmt),
    .tx_left(tx_left), .tx_right(tx_right), .sdi(sdi),
    .bclk(bclk), .ws(ws), .sdo(sdo), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_right(rx_right));

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ostart(input logic [2:0] f);
    case (f) 3'd0: return 1; 3'd2: return 16; 3'd3: return 14; 3'd4: return 12; default: return 0; endcase
  endfunction
  function automatic int olen(input logic [2:0] f);
    case (f) 3'd0: return 24; 3'd2: return 16; 3'd3: return 18; default: return 20; endcase
  endfunction
  function automatic int ilen(input logic [2:0] f);
    case (f) 3'd0: return 24; 3'd1: return 20; 3'd2, 3'd5: return 16; 3'd3, 3'd6: return 18; default: return 20; endcase
  endfunction
  function automatic int istart(input logic [2:0] f);
    if (f == 3'd0) return 1;
    if (f == 3'd1) return 0;
    return 32 - ilen(f);
  endfunction
  function automatic int clk_per(input logic [1:0] r);
    case (r) 2'd0: return 4; 2'd1: return 6; default: return 8; endcase
  endfunction
  function automatic logic [23:0] topmask(input int len);
    return ~(24'hFFFFFF >> len);
  endfunction
  function automatic string ftag(input logic [2:0] f);
    case (f) 3'd0: return "R4"; 3'd1: return "R5"; 3'd2, 3'd3, 3'd4: return "R6"; default: return "R7"; endcase
  endfunction

  int          slot = 0;
  logic        prev_ws = 1;
  bit          started = 0, pend = 0, hchg = 0;
  logic [2:0]  hfmt = 0;
  logic [1:0]  hrate = 0;
  logic [31:0] obits = 0;
  logic [23:0] in_word = 0;
  logic [23:0] txq[$];
  string       txtag[$];
  logic [24:0] rxq[$];
  string       rxtag[$];

  // driver side: records expected items, drives sdi, completes sdo words
  always @(negedge bclk) if (rst_n) begin
    #1;
    if (ws !== prev_ws) begin
      if (started) begin
        logic [23:0] w, e;
        bit zok;
        w = 0; zok = 1;
        for (int s = 0; s < 32; s++) begin
          int p;
          p = s - ostart(hfmt);
          if (p >= 0 && p < olen(hfmt)) w[23 - p] = obits[s];
          else if (obits[s]) zok = 0;
        end
        e = txq.pop_front() & topmask(olen(hfmt));
        check(slot == 31, "R2 half-frame length", slot, 31);
        check(zok && w == e, txtag.pop_front(), {zok, 7'd0, w}, {8'h80, e});
      end
      if (ws == 1'b0) begin
        hchg = pend; pend = 0; hfmt = fmt; hrate = rate_sel;
      end
      started = 1; slot = 0; prev_ws = ws; obits = 0;
      txq.push_back(ws ? tx_right : tx_left);
      txtag.push_back($sformatf("%s R3 R9%s tx ch%0d", ftag(hfmt), hchg ? " R10" : "", ws));
      in_word = 24'($urandom);
      rxq.push_back({ws, in_word & topmask(ilen(hfmt))});
      rxtag.push_back($sformatf("R8 %s%s rx ch%0d", ftag(hfmt), hchg ? " R10" : "", ws));
    end else begin
      slot++;
      if (slot == 10) begin
        if (ws) tx_right = 24'($urandom); else tx_left = 24'($urandom);
      end
    end
    begin
      int p;
      p = slot - istart(hfmt);
      sdi = (p >= 0 && p < ilen(hfmt)) ? in_word[23 - p] : 1'b0;
    end
  end

  always @(posedge bclk) if (rst_n && started) begin
    #1;
    obits[slot] = sdo;
  end

  // monitor: receive strobes against the scoreboard
  always @(negedge clk) if (rst_n && rx_valid) begin
    if (rxq.size() == 0) check(0, "R8 unexpected strobe", {rx_right, rx_data}, 0);
    else begin
      logic [24:0] e;
      e = rxq.pop_front();
      check({rx_right, rx_data} == e, rxtag.pop_front(), {rx_right, rx_data}, e);
    end
  end

  // bit-clock period
  time tprev = 0; int pexp = 0; bit pvalid = 0;
  always @(negedge bclk) if (rst_n) begin
    #2;
    if (pvalid) check(($time - tprev) == pexp * 20, "R2 bclk period", 32'($time - tprev), 32'(pexp * 20));
    tprev = $time; pexp = clk_per(hrate); pvalid = 1;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    tx_left = 24'hA5C3F1; tx_right = 24'h3C5A96;
    repeat (5) @(negedge clk);
    check(bclk === 1'b1, "R1 bclk reset", bclk, 1);
    check(ws === 1'b1, "R1 ws reset", ws, 1);
    check(sdo === 1'b0, "R1 sdo reset", sdo, 0);
    check(rx_valid === 1'b0, "R1 rx_valid reset", rx_valid, 0);
    check(rx_data === 24'd0, "R1 rx_data reset", rx_data, 0);
    rst_n = 1;
    repeat (3) @(negedge ws);
    for (int f = 0; f < 8; f++) begin
      @(negedge clk);
      fmt = 3'(f); rate_sel = 2'((f + 1) % 4); pend = 1;
      repeat (4) @(negedge ws);
    end
    @(negedge clk);
    summary();
  end
endmodule